// File: doc/BRIEF.md
# Data Marshal Address Buffer

Each core has one of these buffers. During a code segment it watches the core's store traffic and keeps the cache-block addresses written by stores that the compiler flagged as generators. Stores without the flag are ignored. Every address is reduced to its block base. A block that is already held is not stored a second time. The buffer keeps at most a fixed number of blocks. Generator stores that arrive when it is full are dropped, and a sticky overflow flag records that this happened.

A marshal command names the core that will run the next segment. When the command is taken, the buffer sends every held block address, oldest first, on a valid/ready push stream. Each pushed address is paired with the named destination core, so that a separate mover can copy the blocks into that core's cache before its segment starts.

A busy flag is high for the whole drain. While the drain runs, generator stores and further commands are ignored. The drain ends on the handshake that accepts the last entry. At that point the buffer is empty, the overflow flag is cleared, and busy falls.

Top module: `marshal_addr_buf`

## Requirements
- R1: After a synchronous reset, `push_valid`, `busy` and `overflow` are low, and the buffer holds no entries, so a drain started right after reset pushes nothing.
- R2: A store is recorded only if `st_valid` and `st_gen` are both 1. A store with `st_gen`=0 never appears in a drain.
- R3: Recording works on 64-byte blocks. `push_addr` carries the store address with bits [5:0] forced to 0. Stores whose addresses differ only in bits [5:0] share one entry.
- R4: The buffer holds up to 16 distinct blocks. A generator store to a new block when 16 are held is dropped and sets `overflow`. `overflow` stays high until the next drain ends. A store to a block already held never sets `overflow`.
- R5: A drain pushes every held block exactly once, in the order the blocks were first recorded. It moves one entry on each cycle in which `push_valid` and `push_ready` are both high. While `push_ready` is low, `push_valid`, `push_addr` and `push_dest` hold their values.
- R6: Every entry pushed by a drain carries in `push_dest` the `mcmd_dest` value of the command that started that drain.
- R7: `busy` rises in the cycle after a command is taken while idle. It falls on the clock edge that accepts the last entry, or one cycle after it rose if the buffer was empty. When it falls, the buffer is empty and `overflow` is low.
- R8: A generator store is not recorded if it arrives while `busy` is high or in the same cycle as a command that is taken. A command that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | A store is observed this cycle |
| st_addr | input | 48 | Physical byte address of the store |
| st_gen | input | 1 | The store is marked as a generator |
| mcmd_valid | input | 1 | Marshal command |
| mcmd_dest | input | 4 | Destination core for the command |
| push_valid | output | 1 | Push stream entry valid |
| push_addr | output | 48 | Block-aligned address being pushed |
| push_dest | output | 4 | Destination core of the pushed entry |
| push_ready | input | 1 | Consumer accepts the push entry |
| busy | output | 1 | Drain in progress |
| overflow | output | 1 | A generator store was dropped because the buffer was full |

## Verification
The sweep fills the buffer with every count of distinct generator blocks from 0 to 18. Each fill is interleaved with ordinary stores and with repeated stores that hit an already held block at a different byte offset. The drained stream must match the first-recorded order exactly, and `overflow` must be high exactly for fills above 16. Together these separate filtering by flag, block alignment, duplicate suppression and the capacity limit. Each drain runs under one of three ready patterns (always ready, ready two cycles in three, ready every other cycle), which show whether an entry is lost or repeated under backpressure. The bench also sends stores and commands during a drain, and on the same cycle as the starting command, and then runs a second drain that must come back empty.

// File: rtl/mab_pkg.sv
package mab_pkg;
  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_DRAIN = 1'b1
  } drain_st_t;
endpackage

// File: rtl/mab_entry_file.sv
module mab_entry_file #(
  parameter int ADDR_W = 48,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [ADDR_W-1:0]         wr_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [ADDR_W-1:0]         rd_data,
  output logic [DEPTH*ADDR_W-1:0]   all_flat
);
  logic [ADDR_W-1:0] mem [DEPTH];

  // No reset on the array: only the entries below the fill count are ever read.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign all_flat[g*ADDR_W +: ADDR_W] = mem[g];
  end
endmodule

// File: rtl/mab_match.sv
module mab_match #(
  parameter int ADDR_W = 48,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DEPTH*ADDR_W-1:0]  all_flat,
  input  logic [CNT_W-1:0]         fill,
  input  logic [ADDR_W-1:0]        probe,
  output logic                     hit
);
  logic [DEPTH-1:0] hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = (CNT_W'(g) < fill) &&
                        (all_flat[g*ADDR_W +: ADDR_W] == probe);
  end

  assign hit = |hit_vec;

  // R3: duplicate suppression leaves at most one held entry per block
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/mab_ctrl.sv
module mab_ctrl
  import mab_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int DEPTH  = 16,
  parameter int CORE_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic              st_gen,
  input  logic              hit,
  input  logic              mcmd_valid,
  input  logic [CORE_W-1:0] mcmd_dest,
  input  logic [ADDR_W-1:0] rd_data,
  input  logic              push_ready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  fill,
  output logic              push_valid,
  output logic [ADDR_W-1:0] push_addr,
  output logic [CORE_W-1:0] push_dest,
  output logic              busy,
  output logic              overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  drain_st_t        state;
  logic [CNT_W-1:0] rd_ptr;
  logic             cmd_take;
  logic             rec_try;
  logic             full;
  logic             advance;

  assign cmd_take = mcmd_valid && (state == ST_IDLE);
  assign rec_try  = st_valid && st_gen && (state == ST_IDLE) && !cmd_take;
  assign full     = (fill == FULL_CNT);
  assign wr_en    = rec_try && !hit && !full;
  assign wr_idx   = fill[IDX_W-1:0];
  assign rd_idx   = rd_ptr[IDX_W-1:0];
  assign advance  = !push_valid || push_ready;
  assign busy     = (state == ST_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      fill       <= '0;
      rd_ptr     <= '0;
      overflow   <= 1'b0;
      push_valid <= 1'b0;
      push_addr  <= '0;
      push_dest  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmd_take) begin
            state     <= ST_DRAIN;
            rd_ptr    <= '0;
            push_dest <= mcmd_dest;
          end else if (wr_en) begin
            fill <= fill + 1'b1;
          end else if (rec_try && !hit && full) begin
            overflow <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (advance) begin
            if (rd_ptr != fill) begin
              push_valid <= 1'b1;
              push_addr  <= rd_data;
              rd_ptr     <= rd_ptr + 1'b1;
            end else begin
              push_valid <= 1'b0;
              state      <= ST_IDLE;
              fill       <= '0;
              overflow   <= 1'b0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: fill never exceeds capacity
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_CNT);
  // R4: overflow only rises when the buffer was full
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(fill) == FULL_CNT);
  // R5: a stalled push holds its payload
  assert_push_hold_R5: assert property (@(posedge clk) disable iff (rst)
    push_valid && !push_ready |=> push_valid && $stable(push_addr) && $stable(push_dest));
  // R7: no push outside a drain
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !push_valid);
  // R7: end of drain leaves buffer empty and overflow cleared
  assert_drain_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (fill == '0) && !overflow);
  // R8: nothing is recorded while draining
  assert_drain_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy || $stable(fill));
endmodule

// File: rtl/marshal_addr_buf.sv
module marshal_addr_buf #(
  parameter int ADDR_W = 48,
  parameter int BLK_B  = 64,
  parameter int DEPTH  = 16,
  parameter int CORE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_gen,
  input  logic              mcmd_valid,
  input  logic [CORE_W-1:0] mcmd_dest,
  output logic              push_valid,
  output logic [ADDR_W-1:0] push_addr,
  output logic [CORE_W-1:0] push_dest,
  input  logic              push_ready,
  output logic              busy,
  output logic              overflow
);
  localparam int OFF_W = $clog2(BLK_B);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] BLK_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

  logic [ADDR_W-1:0]       st_block;
  logic [ADDR_W-1:0]       rd_data;
  logic [DEPTH*ADDR_W-1:0] all_flat;
  logic [CNT_W-1:0]        fill;
  logic [IDX_W-1:0]        wr_idx;
  logic [IDX_W-1:0]        rd_idx;
  logic                    wr_en;
  logic                    hit;

  assign st_block = st_addr & BLK_MASK;

  mab_entry_file #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_entries (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (st_block),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .all_flat (all_flat)
  );

  mab_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_match (
    .clk      (clk),
    .rst      (rst),
    .all_flat (all_flat),
    .fill     (fill),
    .probe    (st_block),
    .hit      (hit)
  );

  mab_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CORE_W(CORE_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .st_valid   (st_valid),
    .st_gen     (st_gen),
    .hit        (hit),
    .mcmd_valid (mcmd_valid),
    .mcmd_dest  (mcmd_dest),
    .rd_data    (rd_data),
    .push_ready (push_ready),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .rd_idx     (rd_idx),
    .fill       (fill),
    .push_valid (push_valid),
    .push_addr  (push_addr),
    .push_dest  (push_dest),
    .busy       (busy),
    .overflow   (overflow)
  );

  // R3: pushed addresses are always block aligned
  assert_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> (push_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/test_marshal_addr_buf.sv
module test_marshal_addr_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0;
  logic [47:0] st_addr = '0;
  logic        st_gen = 1'b0;
  logic        mcmd_valid = 1'b0;
  logic [3:0]  mcmd_dest = '0;
  logic        push_valid;
  logic [47:0] push_addr;
  logic [3:0]  push_dest;
  logic        push_ready = 1'b0;
  logic        busy;
  logic        overflow;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [47:0] exp_q [DEPTH];
  int          exp_n = 0;
  bit          exp_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  marshal_addr_buf i_marshal_addr_buf (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_addr(st_addr), .st_gen(st_gen),
    .mcmd_valid(mcmd_valid), .mcmd_dest(mcmd_dest), .push_valid(push_valid),
    .push_addr(push_addr), .push_dest(push_dest), .push_ready(push_ready),
    .busy(busy), .overflow(overflow)
  );

  task automatic check(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [47:0] blk(int t, int i);
    return 48'(longint'(t * 97 + i * 13 + 1) << 6) | 48'h0000_4000_0000;
  endfunction

  task automatic do_store(logic [47:0] a, bit g);
    logic [47:0] al;
    bit dup;
    st_valid = 1'b1; st_addr = a; st_gen = g;
    al = a & ~48'h3f;
    dup = 0;
    for (int k = 0; k < exp_n; k++) if (exp_q[k] == al) dup = 1;
    if (g && !dup) begin
      if (exp_n < DEPTH) begin exp_q[exp_n] = al; exp_n++; end
      else exp_ovf = 1;
    end
    @(negedge clk);
    st_valid = 1'b0; st_gen = 1'b0;
  endtask

  task automatic do_drain(int dest, int mode, bit poke);
    int k;
    bit rdy;
    mcmd_valid = 1'b1; mcmd_dest = 4'(dest);
    if (poke) begin st_valid = 1'b1; st_gen = 1'b1; st_addr = blk(500, 1); end
    @(negedge clk);
    mcmd_valid = 1'b0; st_valid = 1'b0; st_gen = 1'b0;
    check(busy == 1'b1, "R7", "busy after command", busy, 1);
    k = 0;
    for (int it = 0; it < 300; it++) begin
      if (!busy) break;
      case (mode)
        0: rdy = 1'b1;
        1: rdy = (it % 3) != 0;
        default: rdy = (it % 2) == 1;
      endcase
      push_ready = rdy;
      // R8: generator store and second command during a drain are ignored
      if (it == 1) begin st_valid = 1'b1; st_gen = 1'b1; st_addr = blk(500, 2); end
      else begin st_valid = 1'b0; st_gen = 1'b0; end
      mcmd_valid = (it == 2);
      mcmd_dest = 4'(dest + 5);
      if (push_valid) begin
        check(push_dest == 4'(dest), "R6", "push_dest", push_dest, dest);
        if (rdy) begin
          if (k < exp_n)
            check(push_addr == exp_q[k], "R5", "push_addr order", push_addr, exp_q[k]);
          else
            check(1'b0, "R5", "extra push", k, exp_n);
          k++;
        end
      end
      @(negedge clk);
    end
    push_ready = 1'b0; st_valid = 1'b0; st_gen = 1'b0; mcmd_valid = 1'b0;
    check(k == exp_n, "R5", "entries pushed", k, exp_n);
    check(busy == 1'b0, "R7", "busy at end", busy, 0);
    check(overflow == 1'b0, "R7", "overflow cleared", overflow, 0);
    @(negedge clk);
    check(busy == 1'b0 && push_valid == 1'b0, "R8", "command while busy ignored", busy, 0);
    exp_n = 0; exp_ovf = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(push_valid == 1'b0, "R1", "push_valid after reset", push_valid, 0);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
    do_drain(3, 0, 0); // R1: fresh buffer drains empty

    for (int t = 0; t <= 18; t++) begin
      for (int i = 0; i < t; i++) begin
        do_store(blk(t, i) | 48'(i % 64), 1'b1);          // R2 recorded
        if (i % 3 == 0) do_store(blk(t, i) | 48'h3f, 1'b1); // R3 duplicate block
        do_store(blk(t, i + 100), 1'b0);                  // R2 ordinary store
      end
      check(overflow == exp_ovf, "R4", "overflow before drain", overflow, exp_ovf);
      do_drain(t % 16, t % 3, (t % 4) == 0);
      do_drain((t + 1) % 16, 0, 0); // R8: stores seen during the drain left nothing
    end

    // R3: address with every low bit set maps to the block base
    do_store(48'hFFFF_FFFF_FFFF, 1'b1);
    do_store(48'hFFFF_FFFF_FFC0, 1'b1);
    do_drain(9, 2, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule